// File: doc/BRIEF.md
# Programming Address Sequencer and Word Map

This block sits behind a serial programming port and models what that port reaches: an address counter and a small nonvolatile word store. The store holds a power-of-two bank of user words, four identification words, one backup calibration word and one configuration word. The framing logic in front of this block decodes its serial commands into one-cycle strobes: mode entry, load, read, increment, program start, program finish and bulk erase. This block acts on those strobes.

After mode entry the counter sits on the configuration-word address. Increment is the only way to move it. The counter climbs through user space into configuration space and wraps from the top address back to zero. The configuration word stays reachable only until the first increment. Programming is split into two strobes. The start strobe takes the pending load word and the current address. The finish strobe commits the word. A commit can only clear bits, because the block never erases during a write. A bulk erase blanks the store. It spares the backup calibration word unless the counter has been walked into configuration space. The configuration word carries a protect bit, and while that bit is 0, reads of user words return zero.

Top module: `prog_map_seq`

## Requirements
- R1: After reset the counter equals the top address (2^(USER_AW+1)-1), `prog_busy` is 0, `rd_vld` is 0 and every stored word is blank (12'hFFF). A read at the top address before any increment returns the configuration word.
- R2: An accepted increment moves the counter up by one. Going from the last user address (2^USER_AW-1) leads to the first configuration-space address (2^USER_AW), and going from the top address leads to 0.
- R3: Once an increment has been accepted after entry, the top address no longer maps the configuration word, even after a wrap brings the counter back to it. Reads there return 0 and commits there are ignored.
- R4: In configuration space, offsets 0 to 3 from its base hold the ID words and offset 4 holds the backup calibration word. These can be read and programmed. Every other address in configuration space reads 0 and ignores commits.
- R5: A load keeps bits 11:0 of the 14-bit `load_data` and ignores bits 13:12. A read strobe yields `rd_vld`=1 in the following cycle, and `rd_data` then carries the word with bits 13:12 at 0.
- R6: A start strobe with a pending load, followed by a finish strobe, stores (old word AND loaded word) at the address captured by the start strobe. The commit then clears the pending load.
- R7: A start strobe with no pending load leaves `prog_busy` at 0. A finish strobe without a program in progress changes nothing.
- R8: While `prog_busy` is 1, the load, increment, erase and start strobes have no effect.
- R9: Bulk erase (when not busy) sets every user word, every ID word and the configuration word to 12'hFFF. It also blanks the backup calibration word, but only when the counter is in configuration space and an increment has been accepted since entry.
- R10: When bit CP_BIT of the configuration word is 0, reads of user addresses return 0. ID, backup and configuration reads are not affected.
- R11: Mode entry returns the counter to the top address and makes the configuration word reachable again. It also drops any pending load and any program in progress without committing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same state as mode entry with a blank store |
| enter_stb | input | 1 | Mode entry |
| load_stb | input | 1 | Latch `load_data` as the pending word |
| load_data | input | 14 | Word to load; bits 13:12 ignored |
| rd_stb | input | 1 | Read word at the counter |
| inc_stb | input | 1 | Increment the counter |
| go_stb | input | 1 | Start programming the current address |
| done_stb | input | 1 | Finish programming and commit |
| erase_stb | input | 1 | Bulk erase |
| rd_data | output | 14 | Read result, valid with `rd_vld` |
| rd_vld | output | 1 | Read result valid |
| pc | output | USER_AW+1 | Program counter |
| prog_busy | output | 1 | Program in progress |

## Verification
The bench builds the block with USER_AW=4, which gives 16 user words and a 32-address space. A single walk then visits every address, and several walks fit in a short run. At that size the step from user space into configuration space, the wrap from the top address and every reserved slot are all reached. The same applies to the configuration word at entry compared with after a wrap, to the bit-clearing commits and to both outcomes of the erase decision for the backup word.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_USER   = 3'd1,
    RG_ID     = 3'd2,
    RG_BACKUP = 3'd3,
    RG_CFG    = 3'd4
  } region_e;

  // Address classification for a space of 2^(uaw+1) words.
  function automatic region_e region_of(input int unsigned a,
                                        input int unsigned uaw,
                                        input logic cfg_open);
    int unsigned base;
    int unsigned top;
    base = 32'd1 << uaw;
    top  = (32'd1 << (uaw + 1)) - 32'd1;
    if (a < base)               return RG_USER;
    else if (a == top)          return cfg_open ? RG_CFG : RG_NONE;
    else if (a < base + 32'd4)  return RG_ID;
    else if (a == base + 32'd4) return RG_BACKUP;
    else                        return RG_NONE;
  endfunction

  // Linear step with wrap from the top address to zero.
  function automatic int unsigned pc_step(input int unsigned a,
                                          input int unsigned uaw);
    int unsigned top;
    top = (32'd1 << (uaw + 1)) - 32'd1;
    return (a == top) ? 32'd0 : a + 32'd1;
  endfunction

endpackage

// File: rtl/pms_counter.sv
module pms_counter
  import pms_pkg::*;
#(
  parameter int USER_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             inc_ok,
  output logic [USER_AW:0] pc_q,
  output logic             cfg_open
);
  localparam int AW = USER_AW + 1;
  localparam logic [AW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= TOP;
      cfg_open <= 1'b1;
    end else if (enter) begin
      pc_q     <= TOP;
      cfg_open <= 1'b1;
    end else if (inc_ok) begin
      pc_q     <= AW'(pc_step(32'(pc_q), USER_AW));
      cfg_open <= 1'b0;
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ok && !enter |=> 32'(pc_q) == pc_step(32'($past(pc_q)), USER_AW));

  // R3
  cfg_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(inc_ok));

  // R11
  entry_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (pc_q == TOP) && cfg_open);

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl #(
  parameter int AW = 11,
  parameter int DW = 12,
  parameter int XW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          load_stb,
  input  logic [XW-1:0] load_data,
  input  logic          go_stb,
  input  logic          done_stb,
  input  logic [AW-1:0] pc,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_word
);
  logic          pend_q;
  logic          busy_q;
  logic [DW-1:0] word_q;
  logic [AW-1:0] paddr_q;
  logic          unused_hi;

  assign unused_hi   = ^load_data[XW-1:DW];
  assign busy        = busy_q;
  assign commit      = busy_q & done_stb & ~enter;
  assign commit_addr = paddr_q;
  assign commit_word = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      word_q  <= '0;
      paddr_q <= '0;
    end else if (enter) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (done_stb) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end else if (go_stb && pend_q) begin
      busy_q  <= 1'b1;
      paddr_q <= pc;
    end else if (load_stb) begin
      pend_q <= 1'b1;
      word_q <= load_data[DW-1:0];
    end
  end

  // R7
  go_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(pend_q));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_stb && !enter |=> busy_q && $stable(paddr_q) && $stable(word_q));

endmodule

// File: rtl/pms_store.sv
module pms_store
  import pms_pkg::*;
#(
  parameter int USER_AW = 10,
  parameter int DW      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  region_e          wr_region,
  input  logic [USER_AW:0] wr_addr,
  input  logic [DW-1:0]    wr_word,
  input  logic             erase_en,
  input  logic             erase_backup,
  input  region_e          rd_region,
  input  logic [USER_AW:0] rd_addr,
  output logic [DW-1:0]    rd_word,
  output logic [DW-1:0]    cfg_word
);
  localparam int WORDS = 1 << USER_AW;
  localparam int IDS   = 4;
  localparam logic [DW-1:0] BLANK = '1;

  logic [DW-1:0] user_q [WORDS];
  logic [DW-1:0] id_q   [IDS];
  logic [DW-1:0] bk_q;
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] wr_now;

  assign cfg_word = cfg_q;

  always_comb begin
    case (rd_region)
      RG_USER:   rd_word = user_q[rd_addr[USER_AW-1:0]];
      RG_ID:     rd_word = id_q[rd_addr[1:0]];
      RG_BACKUP: rd_word = bk_q;
      RG_CFG:    rd_word = cfg_q;
      default:   rd_word = '0;
    endcase
  end

  // Current content of the word a commit targets.
  always_comb begin
    case (wr_region)
      RG_USER:   wr_now = user_q[wr_addr[USER_AW-1:0]];
      RG_ID:     wr_now = id_q[wr_addr[1:0]];
      RG_BACKUP: wr_now = bk_q;
      RG_CFG:    wr_now = cfg_q;
      default:   wr_now = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) user_q[i] <= BLANK;
      for (int j = 0; j < IDS; j++)   id_q[j]   <= BLANK;
      bk_q  <= BLANK;
      cfg_q <= BLANK;
    end else if (erase_en) begin
      for (int i = 0; i < WORDS; i++) user_q[i] <= BLANK;
      for (int j = 0; j < IDS; j++)   id_q[j]   <= BLANK;
      cfg_q <= BLANK;
      if (erase_backup) bk_q <= BLANK;
    end else if (wr_en) begin
      case (wr_region)
        RG_USER:   user_q[wr_addr[USER_AW-1:0]] <= wr_now & wr_word;
        RG_ID:     id_q[wr_addr[1:0]]           <= wr_now & wr_word;
        RG_BACKUP: bk_q                         <= wr_now & wr_word;
        RG_CFG:    cfg_q                        <= wr_now & wr_word;
        default:   ;
      endcase
    end
  end

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !erase_en && wr_region != RG_NONE |=> wr_now == ($past(wr_now) & $past(wr_word)));

  // R4
  none_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !erase_en && wr_region == RG_NONE |=> $stable(bk_q) && $stable(cfg_q));

  // R9
  erase_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (cfg_q == BLANK) && (bk_q == ($past(erase_backup) ? BLANK : $past(bk_q))));

endmodule

// File: rtl/pms_readout.sv
module pms_readout
  import pms_pkg::*;
#(
  parameter int DW     = 12,
  parameter int XW     = 14,
  parameter int CP_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  region_e       rd_region,
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] cfg_word,
  output logic [XW-1:0] rd_data,
  output logic          rd_vld
);
  logic          hide;
  logic [DW-1:0] shown;

  assign hide  = (rd_region == RG_NONE) ||
                 ((rd_region == RG_USER) && !cfg_word[CP_BIT]);
  assign shown = hide ? '0 : rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_stb;
      if (rd_stb) rd_data <= XW'(shown);
    end
  end

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_vld);

  // R5
  rd_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> rd_data[XW-1:DW] == '0);

  // R10
  protect_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_region == RG_USER && !cfg_word[CP_BIT] |=> rd_data == '0);

endmodule

// File: rtl/prog_map_seq.sv
module prog_map_seq
  import pms_pkg::*;
#(
  parameter int USER_AW = 10,
  parameter int CP_BIT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter_stb,
  input  logic               load_stb,
  input  logic [13:0]        load_data,
  input  logic               rd_stb,
  input  logic               inc_stb,
  input  logic               go_stb,
  input  logic               done_stb,
  input  logic               erase_stb,
  output logic [13:0]        rd_data,
  output logic               rd_vld,
  output logic [USER_AW:0]   pc,
  output logic               prog_busy
);
  localparam int AW = USER_AW + 1;
  localparam int DW = 12;
  localparam int XW = 14;

  logic          cfg_open;
  logic          busy;
  logic          inc_ok;
  logic          erase_ok;
  logic          erase_bk;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_word;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] cfg_word;
  region_e       rd_region;
  region_e       wr_region;

  initial begin
    if (USER_AW < 3) $error("USER_AW must be at least 3");
    if (CP_BIT >= DW) $error("CP_BIT out of range");
  end

  // Accepted events, brought out by name.
  assign inc_ok    = inc_stb & ~busy & ~enter_stb;
  assign erase_ok  = erase_stb & ~busy & ~enter_stb;
  assign erase_bk  = pc[USER_AW] & ~cfg_open;
  assign rd_region = region_of(32'(pc), USER_AW, cfg_open);
  assign wr_region = region_of(32'(commit_addr), USER_AW, cfg_open);
  assign prog_busy = busy;

  pms_counter #(.USER_AW(USER_AW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (enter_stb),
    .inc_ok   (inc_ok),
    .pc_q     (pc),
    .cfg_open (cfg_open)
  );

  pms_ctrl #(.AW(AW), .DW(DW), .XW(XW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter       (enter_stb),
    .load_stb    (load_stb),
    .load_data   (load_data),
    .go_stb      (go_stb),
    .done_stb    (done_stb),
    .pc          (pc),
    .busy        (busy),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_word (commit_word)
  );

  pms_store #(.USER_AW(USER_AW), .DW(DW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (commit),
    .wr_region    (wr_region),
    .wr_addr      (commit_addr),
    .wr_word      (commit_word),
    .erase_en     (erase_ok),
    .erase_backup (erase_bk),
    .rd_region    (rd_region),
    .rd_addr      (pc),
    .rd_word      (rd_word),
    .cfg_word     (cfg_word)
  );

  pms_readout #(.DW(DW), .XW(XW), .CP_BIT(CP_BIT)) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .rd_region (rd_region),
    .rd_word   (rd_word),
    .cfg_word  (cfg_word),
    .rd_data   (rd_data),
    .rd_vld    (rd_vld)
  );

endmodule

// File: tb/prog_map_seq_test.sv
module prog_map_seq_test;
  localparam int UAW  = 4;
  localparam int BASE = 16;
  localparam int TOP  = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_stb = 1'b0, load_stb = 1'b0, rd_stb = 1'b0, inc_stb = 1'b0;
  logic        go_stb = 1'b0, done_stb = 1'b0, erase_stb = 1'b0;
  logic [13:0] load_data = '0;
  logic [13:0] rd_data;
  logic        rd_vld;
  logic [4:0]  pc;
  logic        prog_busy;

  int total = 0;
  int bad = 0;

  // Bench model of the store and sequencer
  int m_user [16];
  int m_id [4];
  int m_bk, m_cfg, m_pc, m_word, m_paddr;
  bit m_open, m_pend, m_busy;

  always #10 clk = ~clk;

  prog_map_seq #(.USER_AW(UAW), .CP_BIT(3)) uut (
    .clk(clk), .rst_n(rst_n), .enter_stb(enter_stb), .load_stb(load_stb),
    .load_data(load_data), .rd_stb(rd_stb), .inc_stb(inc_stb), .go_stb(go_stb),
    .done_stb(done_stb), .erase_stb(erase_stb), .rd_data(rd_data), .rd_vld(rd_vld),
    .pc(pc), .prog_busy(prog_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 user, 2 id, 3 backup, 4 config
  function automatic int kind(input int a);
    if (a < BASE) return 1;
    if (a == TOP) return m_open ? 4 : 0;
    if (a < BASE + 4) return 2;
    if (a == BASE + 4) return 3;
    return 0;
  endfunction

  function automatic int exp_read(input int a);
    case (kind(a))
      1: return ((m_cfg >> 3) & 1) == 0 ? 0 : m_user[a];
      2: return m_id[a - BASE];
      3: return m_bk;
      4: return m_cfg;
      default: return 0;
    endcase
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: enter_stb = 1'b1;
      1: load_stb  = 1'b1;
      2: inc_stb   = 1'b1;
      3: go_stb    = 1'b1;
      4: done_stb  = 1'b1;
      5: erase_stb = 1'b1;
      default: rd_stb = 1'b1;
    endcase
    @(negedge clk);
    {enter_stb, load_stb, inc_stb, go_stb, done_stb, erase_stb, rd_stb} = '0;
  endtask

  task automatic post(input string tag);
    chk({tag, " pc"}, int'(pc), m_pc);
    chk({tag, " busy"}, int'(prog_busy), int'(m_busy));
  endtask

  task automatic op_enter(input string tag);
    pulse(0);
    m_pc = TOP; m_open = 1; m_pend = 0; m_busy = 0;
    post(tag);
  endtask

  task automatic op_load(input int d, input string tag);
    load_data = 14'(d);
    pulse(1);
    if (!m_busy) begin m_pend = 1; m_word = d & 12'hFFF; end
    post(tag);
  endtask

  task automatic op_inc(input string tag);
    pulse(2);
    if (!m_busy) begin m_pc = (m_pc == TOP) ? 0 : m_pc + 1; m_open = 0; end
    post(tag);
  endtask

  task automatic op_go(input string tag);
    pulse(3);
    if (!m_busy && m_pend) begin m_busy = 1; m_paddr = m_pc; end
    post(tag);
  endtask

  task automatic op_done(input string tag);
    pulse(4);
    if (m_busy) begin
      case (kind(m_paddr))
        1: m_user[m_paddr] &= m_word;
        2: m_id[m_paddr - BASE] &= m_word;
        3: m_bk &= m_word;
        4: m_cfg &= m_word;
        default: ;
      endcase
      m_busy = 0; m_pend = 0;
    end
    post(tag);
  endtask

  task automatic op_erase(input string tag);
    bit kill_bk;
    kill_bk = (m_pc >= BASE) && !m_open;
    pulse(5);
    if (!m_busy) begin
      for (int i = 0; i < 16; i++) m_user[i] = 12'hFFF;
      for (int i = 0; i < 4; i++) m_id[i] = 12'hFFF;
      m_cfg = 12'hFFF;
      if (kill_bk) m_bk = 12'hFFF;
    end
    post(tag);
  endtask

  task automatic rd_chk(input string tag);
    int e;
    e = exp_read(m_pc);
    pulse(6);
    chk({tag, " vld"}, int'(rd_vld), 1);
    chk({tag, " data"}, int'(rd_data), e);
  endtask

  task automatic prog(input int d, input string tag);
    op_load(d, tag);
    op_go(tag);
    op_done(tag);
  endtask

  task automatic walk_read(input string tag);
    for (int i = 0; i < 32; i++) begin
      rd_chk(tag);
      op_inc("R2");
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_user[i] = 12'hFFF;
    for (int i = 0; i < 4; i++) m_id[i] = 12'hFFF;
    m_bk = 12'hFFF; m_cfg = 12'hFFF;
    m_pc = TOP; m_open = 1; m_pend = 0; m_busy = 0; m_word = 0; m_paddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", int'(pc), TOP);
    chk("R1 busy", int'(prog_busy), 0);
    chk("R1 vld", int'(rd_vld), 0);
    rd_chk("R1");
    // R5 config word at entry, high load bits dropped
    prog(14'h3ABC, "R5");
    rd_chk("R5");
    // R2 R4 R3: program and read every address
    op_inc("R2");
    for (int i = 0; i < 32; i++) begin
      prog(14'h2000 | ((i * 173 + 53) & 12'hFFF), "R4");
      rd_chk(i == TOP ? "R3" : "R4");
      op_inc("R2");
    end
    // R6 bits only clear
    prog(14'h0F0F, "R6");
    rd_chk("R6");
    // R7 start without load, finish without start
    op_go("R7");
    op_done("R7");
    rd_chk("R7");
    // R8 strobes ignored while busy
    op_load(14'h0555, "R8");
    op_go("R8");
    op_inc("R8");
    op_load(14'h0000, "R8");
    op_erase("R8");
    op_go("R8");
    op_done("R8");
    rd_chk("R8");
    // R10 code protect
    op_enter("R11");
    prog(14'h00F7, "R10");
    rd_chk("R10");
    op_inc("R2");
    walk_read("R10");
    // R9 erase in user space keeps backup
    op_erase("R9");
    walk_read("R9");
    op_enter("R11");
    rd_chk("R9");
    // R9 erase at entry keeps backup
    op_erase("R9");
    op_inc("R2");
    walk_read("R9");
    for (int i = 0; i < BASE + 4; i++) op_inc("R2");
    prog(14'h0123, "R9");
    for (int i = 0; i < 4; i++) begin
      rd_chk("R9");
      op_inc("R2");
    end
    rd_chk("R9");
    // R9 erase in config space after increment clears backup
    op_erase("R9");
    rd_chk("R9");
    // R11 entry drops a program in progress
    op_load(14'h0000, "R11");
    op_go("R11");
    op_enter("R11");
    op_done("R11");
    rd_chk("R11");
    op_go("R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule